// File: doc/BRIEF.md
# Stepwise Boost Governor for a Core Cluster

This block sets the voltage/frequency operating point of a group of cores. The point is a 4-bit level index. The block moves it by at most one step on each control-period tick. Several conditions decide the move. The measured temperature, power and current are each compared against their own limit. A ceiling table gives the highest level allowed for the number of cores that are currently active, and more active cores map to lower ceilings. The level climbs only while every measurement is strictly below its limit. It descends one step per tick while any measurement is above its limit, or while the current ceiling sits below the present level. It never goes below the nominal level.

An optional protection mode reacts to a critical temperature. When it is enabled and temperature reaches the critical threshold on a tick, the level returns straight to nominal. A programmable number of further ticks must then pass before any new upward step is allowed. A boosting flag shows that the cluster is running above nominal.

The governor is driven by a slow control tick from the surrounding power manager. Its level output feeds the regulator and clock sequencing logic.

Top module: `dvfs_boost_gov`

## Requirements
- R1: After reset the level equals `nominal_lvl` and `boosting` is low. At all times the level is `nominal_lvl` plus an internal boost count, capped at 15, so a change of `nominal_lvl` moves the level by the same amount without a tick.
- R2: With `tick` low the level keeps its value whatever the other inputs do.
- R3: An upward step happens only on a tick where temperature, power and current are each strictly below their limits. A measurement equal to its limit blocks the step but causes no descent.
- R4: The level never rises above the larger of `nominal_lvl` and the ceiling table entry for `act_cores`. Entry i sits in `ceil_tbl[4i+3:4i]`. Counts above NCORES use entry NCORES.
- R5: On a tick where any measurement is above its limit, the level drops by exactly one, and it stops at `nominal_lvl`.
- R6: On a tick where the ceiling is below the present level, the level drops by one even if all limits are met. It settles at the ceiling.
- R7: With `crit_mode_en` high, a tick where temperature is greater than or equal to `temp_crit` returns the level to `nominal_lvl` in that single update. With the mode low, the critical threshold has no effect.
- R8: After such a forced return, the next `cooldown_len` ticks cannot raise the level. The tick after them may raise it.
- R9: `boosting` is high exactly when the level is above `nominal_lvl`.
- R10: Apart from the forced return, one tick changes the level by no more than one step. The level is updated on the clock edge where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Control-period pulse, one cycle wide |
| temp_meas | input | TEMP_W | Measured temperature |
| pwr_meas | input | PWR_W | Measured power |
| cur_meas | input | CUR_W | Measured current |
| temp_lim | input | TEMP_W | Temperature limit |
| pwr_lim | input | PWR_W | Power limit |
| cur_lim | input | CUR_W | Current limit |
| temp_crit | input | TEMP_W | Critical temperature threshold |
| crit_mode_en | input | 1 | Enables forced return and cool-down |
| cooldown_len | input | CNT_W | Cool-down length in ticks |
| act_cores | input | ACT_W | Number of active cores |
| nominal_lvl | input | LVL_W | Nominal level index |
| ceil_tbl | input | (NCORES+1)*LVL_W | Ceiling per active-core count, entry i at bits [LVL_W*i +: LVL_W] |
| level | output | LVL_W | Current level index |
| boosting | output | 1 | Level above nominal |

## Verification
A temperature that reaches the critical threshold while protection mode is enabled is also above the ordinary temperature limit. On that tick the forced return and the one-step descent both apply. The bench raises temperature to exactly the critical value with the mode enabled, and again with it disabled, starting from the top of the ceiling each time. A correct result is a landing at nominal in one update with the mode enabled and a single-step fall with it disabled. A second overlap is a ceiling drop arriving while the limits are met. There the bench expects the descent to take priority over any climb, one step per tick.

// File: rtl/dvfs_gov_pkg.sv
package dvfs_gov_pkg;

  // Summary of one comparison pass over the three sensors
  typedef struct packed {
    logic t_over;
    logic p_over;
    logic c_over;
    logic under_all;
    logic crit_hit;
  } lim_stat_t;

  // Kind of move chosen for the next tick
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_FORCE = 2'd3
  } step_e;

endpackage

// File: rtl/dvfs_limit_cmp.sv
module dvfs_limit_cmp
  import dvfs_gov_pkg::*;
#(
  parameter int TEMP_W = 10,
  parameter int PWR_W  = 12,
  parameter int CUR_W  = 10
) (
  input  logic [TEMP_W-1:0] temp_meas,
  input  logic [PWR_W-1:0]  pwr_meas,
  input  logic [CUR_W-1:0]  cur_meas,
  input  logic [TEMP_W-1:0] temp_lim,
  input  logic [PWR_W-1:0]  pwr_lim,
  input  logic [CUR_W-1:0]  cur_lim,
  input  logic [TEMP_W-1:0] temp_crit,
  input  logic              crit_mode_en,
  output lim_stat_t         stat
);

  logic t_below, p_below, c_below;

  always_comb begin
    t_below        = temp_meas < temp_lim;
    p_below        = pwr_meas  < pwr_lim;
    c_below        = cur_meas  < cur_lim;
    stat.t_over    = temp_meas > temp_lim;
    stat.p_over    = pwr_meas  > pwr_lim;
    stat.c_over    = cur_meas  > cur_lim;
    stat.under_all = t_below & p_below & c_below;
    stat.crit_hit  = crit_mode_en & (temp_meas >= temp_crit);
  end

endmodule

// File: rtl/dvfs_ceiling_sel.sv
module dvfs_ceiling_sel #(
  parameter int NCORES = 4,
  parameter int LVL_W  = 4,
  parameter int ACT_W  = $clog2(NCORES + 1)
) (
  input  logic [ACT_W-1:0]              act_cores,
  input  logic [(NCORES+1)*LVL_W-1:0]   ceil_tbl,
  input  logic [LVL_W-1:0]              nominal,
  output logic [LVL_W-1:0]              max_boost
);

  localparam int N_ENT = NCORES + 1;
  localparam logic [ACT_W-1:0] LAST_IDX = ACT_W'(NCORES);

  logic [LVL_W-1:0] entry [N_ENT];
  logic [LVL_W-1:0] sel_ceil;

  generate
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_unpack
      assign entry[gi] = ceil_tbl[gi*LVL_W +: LVL_W];
    end
  endgenerate

  always_comb begin
    sel_ceil = entry[NCORES];
    if (act_cores <= LAST_IDX) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (act_cores == ACT_W'(i)) sel_ceil = entry[i];
      end
    end
    max_boost = (sel_ceil > nominal) ? (sel_ceil - nominal) : '0;
  end

endmodule

// File: rtl/dvfs_cooldown.sv
module dvfs_cooldown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_ret,
  input  logic [CNT_W-1:0] load_val,
  output logic             hold_off
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (force_ret) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hold_off = (cnt_q != '0);

endmodule

// File: rtl/dvfs_step_ctrl.sv
module dvfs_step_ctrl
  import dvfs_gov_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  lim_stat_t        stat,
  input  logic             hold_off,
  input  logic [LVL_W-1:0] max_boost,
  output logic [LVL_W-1:0] boost_q,
  output logic             force_ret
);

  step_e            step;
  logic [LVL_W-1:0] boost_d;
  logic             boost_en;
  logic             over_any;

  // Priority: critical return, limit descent, ceiling descent, climb
  always_comb begin
    over_any = stat.t_over | stat.p_over | stat.c_over;
    step     = STEP_HOLD;
    if (stat.crit_hit)
      step = STEP_FORCE;
    else if (over_any && (boost_q != '0))
      step = STEP_DOWN;
    else if (boost_q > max_boost)
      step = STEP_DOWN;
    else if (stat.under_all && !hold_off && (boost_q < max_boost))
      step = STEP_UP;
  end

  always_comb begin
    case (step)
      STEP_UP:    boost_d = boost_q + 1'b1;
      STEP_DOWN:  boost_d = boost_q - 1'b1;
      STEP_FORCE: boost_d = '0;
      default:    boost_d = boost_q;
    endcase
    boost_en  = tick && (step != STEP_HOLD);
    force_ret = tick && (step == STEP_FORCE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        boost_q <= '0;
    else if (boost_en) boost_q <= boost_d;
  end

endmodule

// File: rtl/dvfs_boost_gov.sv
module dvfs_boost_gov
  import dvfs_gov_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int LVL_W  = 4,
  parameter int TEMP_W = 10,
  parameter int PWR_W  = 12,
  parameter int CUR_W  = 10,
  parameter int CNT_W  = 8,
  parameter int ACT_W  = $clog2(NCORES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [TEMP_W-1:0]             temp_meas,
  input  logic [PWR_W-1:0]              pwr_meas,
  input  logic [CUR_W-1:0]              cur_meas,
  input  logic [TEMP_W-1:0]             temp_lim,
  input  logic [PWR_W-1:0]              pwr_lim,
  input  logic [CUR_W-1:0]              cur_lim,
  input  logic [TEMP_W-1:0]             temp_crit,
  input  logic                          crit_mode_en,
  input  logic [CNT_W-1:0]              cooldown_len,
  input  logic [ACT_W-1:0]              act_cores,
  input  logic [LVL_W-1:0]              nominal_lvl,
  input  logic [(NCORES+1)*LVL_W-1:0]   ceil_tbl,
  output logic [LVL_W-1:0]              level,
  output logic                          boosting
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  lim_stat_t        stat;
  logic [LVL_W-1:0] max_boost;
  logic [LVL_W-1:0] boost_q;
  logic             hold_off;
  logic             force_ret;
  logic [LVL_W:0]   lvl_sum;

  dvfs_limit_cmp #(
    .TEMP_W(TEMP_W), .PWR_W(PWR_W), .CUR_W(CUR_W)
  ) u_cmp (
    .temp_meas    (temp_meas),
    .pwr_meas     (pwr_meas),
    .cur_meas     (cur_meas),
    .temp_lim     (temp_lim),
    .pwr_lim      (pwr_lim),
    .cur_lim      (cur_lim),
    .temp_crit    (temp_crit),
    .crit_mode_en (crit_mode_en),
    .stat         (stat)
  );

  dvfs_ceiling_sel #(
    .NCORES(NCORES), .LVL_W(LVL_W), .ACT_W(ACT_W)
  ) u_ceil (
    .act_cores (act_cores),
    .ceil_tbl  (ceil_tbl),
    .nominal   (nominal_lvl),
    .max_boost (max_boost)
  );

  dvfs_cooldown #(
    .CNT_W(CNT_W)
  ) u_cool (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .force_ret (force_ret),
    .load_val  (cooldown_len),
    .hold_off  (hold_off)
  );

  dvfs_step_ctrl #(
    .LVL_W(LVL_W)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .stat      (stat),
    .hold_off  (hold_off),
    .max_boost (max_boost),
    .boost_q   (boost_q),
    .force_ret (force_ret)
  );

  always_comb begin
    lvl_sum  = {1'b0, nominal_lvl} + {1'b0, boost_q};
    level    = lvl_sum[LVL_W] ? '1 : lvl_sum[LVL_W-1:0];
    boosting = (boost_q != '0);
  end

endmodule

// File: rtl/dvfs_boost_gov_chk.sv
module dvfs_boost_gov_chk #(
  parameter int NCORES = 4,
  parameter int LVL_W  = 4,
  parameter int TEMP_W = 10,
  parameter int PWR_W  = 12,
  parameter int CUR_W  = 10,
  parameter int CNT_W  = 8,
  parameter int ACT_W  = $clog2(NCORES + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic [TEMP_W-1:0]           temp_meas,
  input logic [PWR_W-1:0]            pwr_meas,
  input logic [CUR_W-1:0]            cur_meas,
  input logic [TEMP_W-1:0]           temp_lim,
  input logic [PWR_W-1:0]            pwr_lim,
  input logic [CUR_W-1:0]            cur_lim,
  input logic [TEMP_W-1:0]           temp_crit,
  input logic                        crit_mode_en,
  input logic [CNT_W-1:0]            cooldown_len,
  input logic [ACT_W-1:0]            act_cores,
  input logic [LVL_W-1:0]            nominal_lvl,
  input logic [(NCORES+1)*LVL_W-1:0] ceil_tbl,
  input logic [LVL_W-1:0]            level
);

  logic             under_c, over_c, crit_c;
  logic [LVL_W-1:0] tbl_c, ceil_c;
  logic [CNT_W-1:0] cd_cnt;

  always_comb begin
    under_c = (temp_meas < temp_lim) && (pwr_meas < pwr_lim) && (cur_meas < cur_lim);
    over_c  = (temp_meas > temp_lim) || (pwr_meas > pwr_lim) || (cur_meas > cur_lim);
    crit_c  = crit_mode_en && (temp_meas >= temp_crit);
    tbl_c   = ceil_tbl[NCORES*LVL_W +: LVL_W];
    for (int i = 0; i < NCORES; i++) begin
      if (act_cores == ACT_W'(i)) tbl_c = ceil_tbl[i*LVL_W +: LVL_W];
    end
    ceil_c = (tbl_c > nominal_lvl) ? tbl_c : nominal_lvl;
  end

  // Ticks left in the cool-down window after a forced return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cd_cnt <= '0;
    else if (tick && crit_c)         cd_cnt <= cooldown_len;
    else if (tick && cd_cnt != '0)   cd_cnt <= cd_cnt - 1'b1;
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick ##1 $stable(nominal_lvl)) |-> $stable(level));

  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick ##1 $stable(nominal_lvl)) |->
      ((level == $past(level)) ||
       ({1'b0, level} == {1'b0, $past(level)} + 1'b1) ||
       ({1'b0, level} + 1'b1 == {1'b0, $past(level)}) ||
       (level == nominal_lvl)));

  a_r3_up_needs_all_under: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick && !under_c) ##1 $stable(nominal_lvl)) |-> (level <= $past(level)));

  a_r4_ceiling_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick && (level >= ceil_c)) ##1 $stable(nominal_lvl)) |-> (level <= $past(level)));

  a_r5_over_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick && over_c && !crit_c && (level > nominal_lvl)) ##1 $stable(nominal_lvl))
      |-> ({1'b0, level} + 1'b1 == {1'b0, $past(level)}));

  a_r7_forced_return: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && crit_c) |=> (level == $past(nominal_lvl)));

  a_r8_cooldown_blocks_up: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick && (cd_cnt != '0)) ##1 $stable(nominal_lvl)) |-> (level <= $past(level)));

endmodule

bind dvfs_boost_gov dvfs_boost_gov_chk #(
  .NCORES(NCORES), .LVL_W(LVL_W), .TEMP_W(TEMP_W), .PWR_W(PWR_W),
  .CUR_W(CUR_W), .CNT_W(CNT_W), .ACT_W(ACT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick         (tick),
  .temp_meas    (temp_meas),
  .pwr_meas     (pwr_meas),
  .cur_meas     (cur_meas),
  .temp_lim     (temp_lim),
  .pwr_lim      (pwr_lim),
  .cur_lim      (cur_lim),
  .temp_crit    (temp_crit),
  .crit_mode_en (crit_mode_en),
  .cooldown_len (cooldown_len),
  .act_cores    (act_cores),
  .nominal_lvl  (nominal_lvl),
  .ceil_tbl     (ceil_tbl),
  .level        (level)
);

// File: tb/dvfs_boost_gov_tb.sv
module dvfs_boost_gov_tb;

  localparam int NC = 4;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [9:0]  temp_meas, temp_lim, temp_crit;
  logic [11:0] pwr_meas, pwr_lim;
  logic [9:0]  cur_meas, cur_lim;
  logic        crit_mode_en;
  logic [7:0]  cooldown_len;
  logic [2:0]  act_cores;
  logic [3:0]  nominal_lvl;
  logic [19:0] ceil_tbl;
  logic [3:0]  level;
  logic        boosting;

  int errors = 0;
  int checks = 0;
  int eb  = 0;   // expected boost above nominal
  int ecd = 0;   // expected cool-down ticks remaining

  // Ceiling entries for 0..4 active cores
  int tblv [5] = '{12, 11, 9, 7, 5};

  dvfs_boost_gov u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .temp_meas(temp_meas), .pwr_meas(pwr_meas), .cur_meas(cur_meas),
    .temp_lim(temp_lim), .pwr_lim(pwr_lim), .cur_lim(cur_lim),
    .temp_crit(temp_crit), .crit_mode_en(crit_mode_en),
    .cooldown_len(cooldown_len), .act_cores(act_cores),
    .nominal_lvl(nominal_lvl), .ceil_tbl(ceil_tbl),
    .level(level), .boosting(boosting)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int max_boost(input int a, input int nom);
    int ent;
    ent = (a > NC) ? tblv[NC] : tblv[a];
    return (ent > nom) ? ent - nom : 0;
  endfunction

  function automatic int exp_level();
    int s;
    s = int'(nominal_lvl) + eb;
    return (s > 15) ? 15 : s;
  endfunction

  // One control tick: predict, apply, then compare at the following negedge
  task automatic do_tick(input string tag);
    bit over, under, crit, allowed;
    int mb;
    over  = (temp_meas > temp_lim) || (pwr_meas > pwr_lim) || (cur_meas > cur_lim);
    under = (temp_meas < temp_lim) && (pwr_meas < pwr_lim) && (cur_meas < cur_lim);
    crit  = crit_mode_en && (temp_meas >= temp_crit);
    mb    = max_boost(int'(act_cores), int'(nominal_lvl));
    if (crit) begin
      eb  = 0;
      ecd = int'(cooldown_len);
    end else begin
      allowed = (ecd == 0);
      if (ecd != 0) ecd--;
      if (over && eb > 0)                       eb--;
      else if (eb > mb)                         eb--;
      else if (under && allowed && eb < mb)     eb++;
    end
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    check(int'(level) == exp_level(), tag, int'(level), exp_level());
    check(boosting == (eb != 0), "R9 boosting", int'(boosting), int'(eb != 0));
  endtask

  task automatic set_quiet();
    temp_meas = 10'd100;
    pwr_meas  = 12'd100;
    cur_meas  = 10'd100;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0;
    temp_lim = 10'd500; pwr_lim = 12'd1000; cur_lim = 10'd300; temp_crit = 10'd600;
    set_quiet();
    crit_mode_en = 1'b0; cooldown_len = 8'd0; act_cores = 3'd0; nominal_lvl = 4'd6;
    ceil_tbl = {4'd5, 4'd7, 4'd9, 4'd11, 4'd12};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(level == 4'd6, "R1 reset level", int'(level), 6);
    check(boosting == 1'b0, "R1 reset boosting", int'(boosting), 0);

    // R2 no movement without a tick, conditions favour a climb
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(level == 4'd6, "R2 hold without tick", int'(level), 6);
    end

    // R4 / R10 sweep over every active-core count, including out of range
    for (int a = 0; a <= 5; a++) begin
      act_cores = 3'(a);
      temp_meas = 10'd501;
      while (eb != 0) do_tick("R5 descend");
      set_quiet();
      do_tick("R10 first step");
      for (int k = 0; k < 8; k++) do_tick("R10 ramp");
      check(int'(level) == 6 + max_boost(a, 6), "R4 ceiling per count",
            int'(level), 6 + max_boost(a, 6));
    end

    // R3 / R5 each sensor at and above its limit, starting at 12
    act_cores = 3'd0;
    for (int k = 0; k < 8; k++) do_tick("R10 ramp");
    for (int s = 0; s < 3; s++) begin
      set_quiet();
      if (s == 0) temp_meas = temp_lim;
      if (s == 1) pwr_meas  = pwr_lim;
      if (s == 2) cur_meas  = cur_lim;
      do_tick("R3 equal limit");
      check(level == 4'd12, "R3 equal holds", int'(level), 12);
      if (s == 0) temp_meas = temp_lim + 10'd1;
      if (s == 1) pwr_meas  = pwr_lim + 12'd1;
      if (s == 2) cur_meas  = cur_lim + 10'd1;
      do_tick("R5 over limit");
      check(level == 4'd11, "R5 one step down", int'(level), 11);
      set_quiet();
      do_tick("R3 recover");
    end

    // R5 persistent overload floors at nominal
    pwr_meas = 12'd2000;
    for (int k = 0; k < 9; k++) do_tick("R5 descend");
    check(level == 4'd6, "R5 floor at nominal", int'(level), 6);

    // R6 ceiling drop with limits met
    set_quiet();
    for (int k = 0; k < 8; k++) do_tick("R10 ramp");
    act_cores = 3'd3;
    for (int k = 0; k < 7; k++) do_tick("R6 ceiling descent");
    check(level == 4'd7, "R6 settles at ceiling", int'(level), 7);

    // R1 level follows nominal without a tick
    nominal_lvl = 4'd4;
    @(negedge clk);
    check(level == 4'd5, "R1 nominal follow", int'(level), 5);
    nominal_lvl = 4'd6;
    @(negedge clk);
    check(level == 4'd7, "R1 nominal restore", int'(level), 7);

    // R7 critical temperature ignored with mode off
    act_cores = 3'd0;
    for (int k = 0; k < 8; k++) do_tick("R10 ramp");
    temp_meas = temp_crit;
    do_tick("R7 mode off");
    check(level == 4'd11, "R7 mode off single step", int'(level), 11);

    // R7 / R8 forced return and cool-down of several lengths
    for (int cd = 0; cd < 4; cd++) begin
      crit_mode_en = 1'b0;
      cooldown_len = 8'(cd);
      set_quiet();
      for (int k = 0; k < 8; k++) do_tick("R10 ramp");
      crit_mode_en = 1'b1;
      temp_meas = temp_crit;
      do_tick("R7 forced");
      check(level == 4'd6, "R7 forced return", int'(level), 6);
      set_quiet();
      for (int k = 0; k < cd; k++) do_tick("R8 cooldown hold");
      check(level == 4'd6, "R8 held during cooldown", int'(level), 6);
      do_tick("R8 release");
      check(level == 4'd7, "R8 climb after cooldown", int'(level), 7);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule